// File: doc/BRIEF.md
# Streaming Write Allocation Mode Tracker

This block watches the write requests that reach a cache and, on every accepted write, updates a policy that says whether the cache should allocate lines for writes, merge them into full lines first, or stop allocating and send them straight through. It detects a streaming pattern by keeping the address where the last write ended and comparing each new write address against it. While a stream continues, it sums the bytes written. Two limits, supplied as inputs, move the policy from allocate to coalesce and then from coalesce to bypass. Any write that breaks the stream restarts the count and returns the policy to allocate.

Beside the policy, a small table of countdown timers, selected by the low bits of the line number, tells the cache which lines have recently received a write that continues a stream. The cache can hold a partial write to such a line so that the following writes merge with it. A write that continues a stream reloads the timer of its line with a threshold. A write that breaks the stream clears that timer. Every timer that is not zero counts down by one each cycle.

All state is registered. A write presented on a rising edge is visible on the outputs after that edge.

Top module: `stream_wr_alloc_tracker`

## Requirements
- R1: A write is sequential when `wr_addr_i` equals the expected next address. After each accepted write, the expected next address becomes `wr_addr_i + wr_size_i`, taken modulo 2^ADDR_W. Reset sets it to 0.
- R2: On a sequential write outside bypass mode, the run byte count grows by `wr_size_i`. It saturates at 2^CNT_W-1 and never wraps.
- R3: In allocate mode, a sequential write that leaves the count strictly greater than `coal_limit_i` moves the mode to coalesce. A count equal to the limit keeps allocate.
- R4: In coalesce mode, a sequential write that leaves the count strictly greater than `bypass_limit_i` moves the mode to bypass. One write advances the mode by at most one step.
- R5: In bypass mode, sequential writes leave the mode in bypass and do not change the count.
- R6: A non-sequential write sets the count to its own size, saturated, and returns the mode to allocate in every mode. On that write the count is not compared against either limit.
- R7: `mode_o` encodes allocate as 0, coalesce as 1 and bypass as 2. `allocate_o` is high only in allocate mode. `coalesce_o` is high in coalesce and in bypass mode.
- R8: The timer table has DLY_ENTRIES entries, selected by `wr_blk_i[IDX_W-1:0]`. A sequential write loads its entry with `dly_thresh_i`. A non-sequential write clears its entry. A write to an entry takes priority over that entry's countdown in the same cycle. Every other nonzero entry decreases by 1 per cycle. `dly_flags_o[i]` is high while entry i is nonzero.
- R9: While `rst_ni` is low, the mode is allocate, the count is 0, the expected address is 0 and all timers are 0.
- R10: A cycle with `wr_valid_i` low changes nothing except the countdown of the timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | A write is presented this cycle |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_size_i | input | SIZE_W | Size of the write in bytes |
| wr_blk_i | input | BLK_W | Line number of the write |
| coal_limit_i | input | CNT_W | Byte count above which allocate moves to coalesce |
| bypass_limit_i | input | CNT_W | Byte count above which coalesce moves to bypass |
| dly_thresh_i | input | DLY_W | Value loaded into a timer on a sequential write |
| mode_o | output | 2 | Current policy: 0 allocate, 1 coalesce, 2 bypass |
| allocate_o | output | 1 | Writes should allocate |
| coalesce_o | output | 1 | Writes should be coalesced |
| dly_flags_o | output | DLY_ENTRIES | Per-entry flag, high while the timer is nonzero |

## Verification
A write can land on a timer entry in the same cycle that the entry would count down. The bench provokes this by writing to a line whose timer is still running, once as a sequential write and once as a non-sequential write. It also uses a second line number that maps to the same entry. It judges the result by the cycles the flag stays high afterwards: a sequential write must restart the full threshold, and a non-sequential write must drop the flag on the next cycle. A non-sequential write can also meet a mode change: a restart whose size alone exceeds the coalesce limit must still leave the mode at allocate.

// File: rtl/swa_pkg.sv
package swa_pkg;
  typedef enum logic [1:0] {
    MODE_ALLOC  = 2'd0,
    MODE_COAL   = 2'd1,
    MODE_BYPASS = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/swa_seq_detect.sv
module swa_seq_detect #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  output logic              seq_hit_o
);
  logic [ADDR_W-1:0] next_q;
  logic [ADDR_W-1:0] size_ext;

  assign size_ext  = ADDR_W'(wr_size_i);
  assign seq_hit_o = (wr_addr_i == next_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) next_q <= '0;
    else if (wr_valid_i) next_q <= wr_addr_i + size_ext;
  end
endmodule

// File: rtl/swa_run_ctrl.sv
module swa_run_ctrl
  import swa_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              seq_hit_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic [CNT_W-1:0]  coal_limit_i,
  input  logic [CNT_W-1:0]  bypass_limit_i,
  output wr_mode_e          mode_o
);
  localparam int SUM_W = ((CNT_W > SIZE_W) ? CNT_W : SIZE_W) + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

  wr_mode_e          mode_q, mode_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SUM_W-1:0]  run_sum, size_only;
  logic [CNT_W-1:0]  run_sat, size_sat;

  assign run_sum   = SUM_W'(cnt_q) + SUM_W'(wr_size_i);
  assign size_only = SUM_W'(wr_size_i);
  assign run_sat   = (run_sum > CNT_MAX) ? {CNT_W{1'b1}} : run_sum[CNT_W-1:0];
  assign size_sat  = (size_only > CNT_MAX) ? {CNT_W{1'b1}} : size_only[CNT_W-1:0];

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (wr_valid_i) begin
      if (seq_hit_i) begin
        if (mode_q != MODE_BYPASS) begin
          cnt_d = run_sat;
          if (mode_q == MODE_ALLOC && run_sat > coal_limit_i)
            mode_d = MODE_COAL;
          else if (mode_q == MODE_COAL && run_sat > bypass_limit_i)
            mode_d = MODE_BYPASS;
        end
      end else begin
        cnt_d  = size_sat;
        mode_d = MODE_ALLOC;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_ALLOC;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/swa_delay_table.sv
module swa_delay_table #(
  parameter int DLY_ENTRIES = 8,
  parameter int DLY_W       = 8,
  parameter int IDX_W       = (DLY_ENTRIES > 1) ? $clog2(DLY_ENTRIES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_valid_i,
  input  logic                   seq_hit_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [DLY_W-1:0]       thresh_i,
  output logic [DLY_ENTRIES-1:0] busy_o
);
  for (genvar g = 0; g < DLY_ENTRIES; g++) begin : g_ent
    logic [DLY_W-1:0] tmr_q;
    logic             sel;

    assign sel = wr_valid_i && (idx_i == IDX_W'(g));

    // a write to this entry wins over its countdown
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            tmr_q <= '0;
      else if (sel)           tmr_q <= seq_hit_i ? thresh_i : '0;
      else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
    end

    assign busy_o[g] = (tmr_q != '0);
  end
endmodule

// File: rtl/stream_wr_alloc_tracker.sv
module stream_wr_alloc_tracker
  import swa_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 8,
  parameter int BLK_W       = 26,
  parameter int CNT_W       = 16,
  parameter int DLY_W       = 8,
  parameter int DLY_ENTRIES = 8,
  localparam int IDX_W      = (DLY_ENTRIES > 1) ? $clog2(DLY_ENTRIES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_valid_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [SIZE_W-1:0]      wr_size_i,
  input  logic [BLK_W-1:0]       wr_blk_i,
  input  logic [CNT_W-1:0]       coal_limit_i,
  input  logic [CNT_W-1:0]       bypass_limit_i,
  input  logic [DLY_W-1:0]       dly_thresh_i,
  output logic [1:0]             mode_o,
  output logic                   allocate_o,
  output logic                   coalesce_o,
  output logic [DLY_ENTRIES-1:0] dly_flags_o
);
  logic             seq_hit;
  logic [IDX_W-1:0] blk_idx;
  wr_mode_e         mode;
  logic             unused_blk_hi;

  assign blk_idx       = wr_blk_i[IDX_W-1:0];
  assign unused_blk_hi = ^wr_blk_i;

  swa_seq_detect #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .wr_size_i  (wr_size_i),
    .seq_hit_o  (seq_hit)
  );

  swa_run_ctrl #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_run (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_valid_i     (wr_valid_i),
    .seq_hit_i      (seq_hit),
    .wr_size_i      (wr_size_i),
    .coal_limit_i   (coal_limit_i),
    .bypass_limit_i (bypass_limit_i),
    .mode_o         (mode)
  );

  swa_delay_table #(.DLY_ENTRIES(DLY_ENTRIES), .DLY_W(DLY_W), .IDX_W(IDX_W)) u_dly (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .seq_hit_i  (seq_hit),
    .idx_i      (blk_idx),
    .thresh_i   (dly_thresh_i),
    .busy_o     (dly_flags_o)
  );

  assign mode_o     = mode;
  assign allocate_o = (mode == MODE_ALLOC);
  assign coalesce_o = (mode == MODE_COAL) || (mode == MODE_BYPASS);
endmodule

// File: rtl/swa_checker.sv
module swa_checker #(
  parameter int DLY_ENTRIES = 8,
  parameter int IDX_W       = 3,
  parameter int DLY_W       = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_valid_i,
  input logic                   seq_hit_i,
  input logic [IDX_W-1:0]       blk_idx_i,
  input logic [DLY_W-1:0]       dly_thresh_i,
  input logic [1:0]             mode_i,
  input logic                   allocate_i,
  input logic                   coalesce_i,
  input logic [DLY_ENTRIES-1:0] dly_flags_i
);
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |=> (mode_i != 2'd2)); // R4

  AST_BYPASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && wr_valid_i && seq_hit_i) |=> (mode_i == 2'd2)); // R5

  AST_RESTART_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !seq_hit_i) |=> allocate_i && !coalesce_i); // R6

  AST_IDLE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> $stable(mode_i)); // R10

  AST_DLY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && seq_hit_i && dly_thresh_i != '0) |=> dly_flags_i[$past(blk_idx_i)]); // R8

  AST_DLY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !seq_hit_i) |=> !dly_flags_i[$past(blk_idx_i)]); // R8

  AST_FLAG_RISE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> ($countones(dly_flags_i & ~$past(dly_flags_i)) == 0)); // R8

  AST_MODE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != 2'd3); // R7
endmodule

bind stream_wr_alloc_tracker swa_checker #(
  .DLY_ENTRIES(DLY_ENTRIES), .IDX_W(IDX_W), .DLY_W(DLY_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .seq_hit_i    (seq_hit),
  .blk_idx_i    (blk_idx),
  .dly_thresh_i (dly_thresh_i),
  .mode_i       (mode_o),
  .allocate_i   (allocate_o),
  .coalesce_i   (coalesce_o),
  .dly_flags_i  (dly_flags_o)
);

// File: tb/stream_wr_alloc_tracker_tb.sv
`timescale 1ns/1ps
module stream_wr_alloc_tracker_tb;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 8;
  localparam int BLK_W  = 26;
  localparam int CNT_W  = 8;
  localparam int DLY_W  = 8;
  localparam int NENT   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [SIZE_W-1:0] wr_size = '0;
  logic [BLK_W-1:0]  wr_blk = '0;
  logic [CNT_W-1:0]  coal_lim = 8'd100;
  logic [CNT_W-1:0]  byp_lim = 8'd200;
  logic [DLY_W-1:0]  thr = 8'd5;
  logic [1:0]        mode;
  logic              alloc_o, coal_o;
  logic [NENT-1:0]   flags;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R9";

  // reference state
  int              m_mode = 0;
  int              m_cnt = 0;
  logic [31:0]     m_next = '0;
  int              m_dly [NENT];

  always #10 clk = ~clk;

  stream_wr_alloc_tracker #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BLK_W(BLK_W),
    .CNT_W(CNT_W), .DLY_W(DLY_W), .DLY_ENTRIES(NENT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_size_i(wr_size), .wr_blk_i(wr_blk), .coal_limit_i(coal_lim),
    .bypass_limit_i(byp_lim), .dly_thresh_i(thr), .mode_o(mode),
    .allocate_o(alloc_o), .coalesce_o(coal_o), .dly_flags_o(flags)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_next = '0;
      foreach (m_dly[i]) m_dly[i] = 0;
    end else begin
      foreach (m_dly[i]) if (m_dly[i] > 0) m_dly[i] = m_dly[i] - 1;
      if (wr_valid) begin
        if (wr_addr == m_next) begin
          m_dly[int'(wr_blk) % NENT] = int'(thr);
          if (m_mode != 2) begin
            m_cnt = m_cnt + int'(wr_size);
            if (m_cnt > 255) m_cnt = 255;
            if (m_mode == 0 && m_cnt > int'(coal_lim)) m_mode = 1;
            else if (m_mode == 1 && m_cnt > int'(byp_lim)) m_mode = 2;
          end
        end else begin
          m_dly[int'(wr_blk) % NENT] = 0;
          m_cnt = int'(wr_size);
          m_mode = 0;
        end
        m_next = wr_addr + 32'(wr_size);
      end
    end
  end

  function automatic logic [NENT-1:0] m_flags();
    logic [NENT-1:0] f;
    for (int i = 0; i < NENT; i++) f[i] = (m_dly[i] != 0);
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(mode) == m_mode, cur_req, "mode_o", int'(mode), m_mode);
      check(alloc_o == (m_mode == 0) && coal_o == (m_mode != 0), "R7",
            "allocate_o/coalesce_o", int'({alloc_o, coal_o}),
            int'({m_mode == 0, m_mode != 0}));
      check(flags == m_flags(), "R8", "dly_flags_o", int'(flags), int'(m_flags()));
    end
  end

  task automatic wr(input logic [31:0] a, input int sz, input int blk);
    wr_valid = 1'b1; wr_addr = a; wr_size = SIZE_W'(sz); wr_blk = BLK_W'(blk);
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      wr_addr = 32'hDEAD_0000 + 32'(i); wr_size = 8'hFF; wr_blk = BLK_W'(i);
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset values
    repeat (3) @(negedge clk);
    check(mode == 2'd0 && alloc_o && !coal_o && flags == '0, "R9", "reset outputs",
          int'({mode, alloc_o, coal_o, flags}), int'({2'd0, 1'b1, 1'b0, 8'd0}));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 expected address starts at 0: write at 0 is sequential
    cur_req = "R1"; thr = 8'd3;
    wr(32'h0, 8, 2);
    check(flags[2] == 1'b1, "R1", "seq after reset flag[2]", int'(flags[2]), 1);
    idle(3);

    // R3 boundary at coalesce limit
    cur_req = "R3"; thr = 8'd5;
    wr(32'h1000, 64, 0);
    wr(32'h1040, 32, 1);
    wr(32'h1060, 4, 1);
    check(mode == 2'd0, "R3", "count equal to limit", int'(mode), 0);
    wr(32'h1064, 1, 1);
    check(mode == 2'd1, "R3", "count above limit", int'(mode), 1);

    // R4 boundary and single step
    cur_req = "R4";
    wr(32'h1065, 99, 2);
    check(mode == 2'd1, "R4", "count equal to bypass limit", int'(mode), 1);
    wr(32'h10C8, 1, 2);
    check(mode == 2'd2, "R4", "count above bypass limit", int'(mode), 2);
    wr(32'h2000, 150, 3);
    coal_lim = 8'd10; byp_lim = 8'd20;
    wr(32'h2096, 100, 3);
    check(mode == 2'd1, "R4", "one step per write", int'(mode), 1);

    // R5 bypass sticky
    cur_req = "R5";
    wr(32'h20FA, 10, 4);
    wr(32'h2104, 255, 4);
    wr(32'h2203, 255, 4);
    check(mode == 2'd2, "R5", "bypass holds", int'(mode), 2);

    // R6 restart with size above coalesce limit
    cur_req = "R6"; coal_lim = 8'd100; byp_lim = 8'd200;
    wr(32'h8000, 150, 6);
    check(mode == 2'd0 && alloc_o, "R6", "restart to allocate", int'(mode), 0);
    wr(32'h8096, 10, 6);
    check(mode == 2'd1, "R6", "restart count = size", int'(mode), 1);

    // R2 saturation
    cur_req = "R2"; coal_lim = 8'd250; byp_lim = 8'd254;
    wr(32'h9000, 200, 0);
    check(mode == 2'd0, "R2", "first write", int'(mode), 0);
    wr(32'h90C8, 200, 0);
    check(mode == 2'd1, "R2", "saturated count", int'(mode), 1);
    wr(32'h9190, 1, 0);
    check(mode == 2'd2, "R2", "count held at max", int'(mode), 2);

    // R8 timers, reload against countdown, clear
    cur_req = "R8"; thr = 8'd3;
    wr(32'hA000, 4, 5);
    wr(32'hA004, 4, 5);
    check(flags[5], "R8", "loaded", int'(flags[5]), 1);
    idle(2);
    wr(32'hA008, 4, 13);
    idle(2);
    check(flags[5], "R8", "reload beats countdown", int'(flags[5]), 1);
    idle(1);
    check(!flags[5], "R8", "expired", int'(flags[5]), 0);
    wr(32'hA00C, 4, 5);
    wr(32'hB000, 4, 5);
    check(!flags[5], "R8", "non-seq clears", int'(flags[5]), 0);

    // R10 idle cycles
    cur_req = "R10";
    wr(32'hB004, 4, 1);
    idle(4);
    check(mode == 2'd0, "R10", "idle keeps mode", int'(mode), 0);

    // R1 address wrap
    cur_req = "R1"; thr = 8'd6;
    wr(32'hFFFF_FFF0, 16, 1);
    wr(32'h0, 4, 3);
    check(flags[3], "R1", "wrapped next address", int'(flags[3]), 1);

    // R9 reset mid-run
    cur_req = "R9";
    wr(32'h4, 4, 7);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(mode == 2'd0 && flags == '0, "R9", "reset clears",
          int'({mode, flags}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // mixed stream
    cur_req = "R1"; coal_lim = 8'd120; byp_lim = 8'd240;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      a = ($urandom % 4 != 0) ? m_next : $urandom;
      thr = DLY_W'($urandom % 6);
      wr(a, 1 + ($urandom % 64), $urandom % 64);
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule